// File: doc/BRIEF.md
# Coprocessor I/O Page Decoder with Boot-ROM Overlay

This block sits between a small audio coprocessor's CPU and the rest of its 64 KB address space. Each CPU byte access is classified in the cycle it is presented. Most addresses pass straight through to the external RAM. The sixteen addresses 0x00F0 to 0x00FF are special: they form the I/O page. The 64 bytes from 0xFFC0 to 0xFFFF can be covered by a built-in boot ROM.

Inside the I/O page, the block does several jobs:
- It keeps the control byte, which sets the timer enables, the port clears and the ROM overlay.
- It holds the index of an indirect register window and turns accesses to that window into single-cycle strobes on a DSP register port.
- It presents four communication bytes, which a host loads.
- It turns timer period writes and counter accesses into strobes for timers that live outside the block.

Read data comes back combinationally in the same cycle as the access. Register state changes at the next rising clock edge.

Top module: `copro_io_map`

## Requirements
- R1: After reset, the overlay is enabled, all timer enables are 0, the window index is 0 and all four port bytes are 0.
- R2: A write to 0x00F1 makes timer enables [2:0] equal data bits [2:0] from the next cycle. In the same cycle as that write, `tmr_start[i]` pulses for each timer whose enable goes from 0 to 1.
- R3: A write to 0x00F1 with data bit 4 set clears port bytes 0 and 1 (0x00F4 and 0x00F5). Data bit 5 clears port bytes 2 and 3 (0x00F6 and 0x00F7). A clear wins over a host load in the same cycle.
- R4: Data bit 7 of a write to 0x00F1 sets the overlay state. While the overlay is on, reads of 0xFFC0 to 0xFFFF return ROM bytes. While it is off, those reads return `ram_rdata`.
- R5: Writes to 0xFFC0 to 0xFFFF always assert `ram_we`, whatever the overlay state.
- R6: 0x00F2 is the read/write window index. A read of 0x00F3 pulses `dsp_rd` with `dsp_addr` equal to index bits [6:0], and returns `dsp_rdata`.
- R7: A write to 0x00F3 pulses `dsp_wr` with `dsp_wdata` equal to the written byte, but only when the index is below 128. With index bit 7 set, no strobe is produced.
- R8: A write to 0x00FA, 0x00FB or 0x00FC pulses `tmr_period_we` bit 0, 1 or 2 respectively, and `tmr_period_data` carries the byte. Reads of 0x00F0, 0x00F1 and 0x00FA to 0x00FC return 0.
- R9: A read of 0x00FD, 0x00FE or 0x00FF returns the 4-bit count of timer 0, 1 or 2 in bits [3:0], with the upper bits 0, and pulses that timer's `tmr_cnt_clr` bit. A write to the same address also pulses it.
- R10: Writes to 0x00F0 and to 0x00F4 to 0x00F7 have no effect. They assert no `ram_we` and no strobe, and leave the read-back port bytes and the timer enables unchanged.
- R11: All other addresses, including 0x00F8 and 0x00F9, are RAM. A write asserts `ram_we`, and a read returns `ram_rdata`.
- R12: The ROM is all zero except its last two bytes, which hold the boot vector in little-endian order (default 0xFFC0, so 0xFFFE reads 0xC0 and 0xFFFF reads 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, same cycle |
| ram_we | output | 1 | Write strobe to external RAM |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (asynchronous) |
| host_we | input | 1 | Host load of a port byte |
| host_sel | input | 2 | Port byte selected by host |
| host_data | input | 8 | Host load data |
| dsp_rd | output | 1 | DSP register read strobe |
| dsp_wr | output | 1 | DSP register write strobe |
| dsp_addr | output | 7 | DSP register address |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| tmr_en | output | 3 | Timer enables |
| tmr_start | output | 3 | Pulse when a timer becomes enabled |
| tmr_period_we | output | 3 | Period write strobes |
| tmr_period_data | output | 8 | Period value |
| tmr_cnt_clr | output | 3 | Counter clear strobes |
| tmr_cnt | input | 12 | Three 4-bit counts, timer 0 in bits [3:0] |

## Verification
The bench targets these corner cases, each paired with the symptom a faulty design would show:
- Window index with bit 7 set. A design that forwarded this write would pulse `dsp_wr`. A design that failed to mask the index on reads would drive the wrong `dsp_addr`.
- Write into the ROM range while the overlay is on, then turn the overlay off. A design that gated `ram_we` with the overlay would lose the RAM copy. A design with the wrong read mux would show RAM data while the ROM is active.
- Host load and port clear in the same cycle. A design that let the load win would leave a stale byte in the port.
- Enabling timers with some already on. A design that derived `tmr_start` from the data bits alone would restart timers that were already running.

// File: rtl/cio_pkg.sv
// Package: shared address map constants, region type and ROM content function
// for the coprocessor I/O page decoder. Assumes a 16-bit byte address space.
package cio_pkg;
    localparam int NUM_TMR   = 3;
    localparam int NUM_PORT  = 4;
    localparam int DSP_AW    = 7;

    typedef enum logic [3:0] {
        RG_RAM,
        RG_TEST,
        RG_CTRL,
        RG_IDX,
        RG_WIN,
        RG_PORT,
        RG_PERIOD,
        RG_COUNT,
        RG_ROM
    } region_e;

    // Byte at offset idx of a ROM of nbytes: zero, then the boot vector (low, high)
    function automatic logic [7:0] rom_byte(input int idx, input int nbytes,
                                            input logic [15:0] vec);
        if (idx == nbytes - 2)      rom_byte = vec[7:0];
        else if (idx == nbytes - 1) rom_byte = vec[15:8];
        else                        rom_byte = 8'h00;
    endfunction
endpackage

// File: rtl/cio_decode.sv
// Module: cio_decode
// Classifies a CPU address into a region and a small sub-index (port or timer).
// Assumes the I/O page is 0x00F0..0x00FF and the ROM occupies the top ROM_BYTES.
module cio_decode
    import cio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [1:0]        sub
);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    logic in_page;
    logic in_rom;

    // Page and ROM window detection
    always_comb begin
        in_page = (addr[ADDR_W-1:8] == '0) && (addr[7:4] == 4'hF);
        in_rom  = &addr[ADDR_W-1:ROM_AW];
    end

    // Region selection and sub-index within the I/O page
    always_comb begin
        region = RG_RAM;
        sub    = 2'd0;
        if (in_rom) begin
            region = RG_ROM;
        end else if (in_page) begin
            unique case (addr[3:0])
                4'h0: region = RG_TEST;
                4'h1: region = RG_CTRL;
                4'h2: region = RG_IDX;
                4'h3: region = RG_WIN;
                4'h4, 4'h5, 4'h6, 4'h7: begin
                    region = RG_PORT;
                    sub    = addr[1:0];
                end
                4'h8, 4'h9: region = RG_RAM;
                4'hA, 4'hB, 4'hC: begin
                    region = RG_PERIOD;
                    sub    = 2'(addr[3:0] - 4'hA);
                end
                default: begin
                    region = RG_COUNT;
                    sub    = 2'(addr[3:0] - 4'hD);
                end
            endcase
        end
    end
endmodule

// File: rtl/cio_ctrl.sv
// Module: cio_ctrl
// Holds the control state (timer enables, overlay flag), the window index and
// the four host-loaded port bytes. Assumes write strobes are one cycle wide and
// already qualified by the decoder.
module cio_ctrl
    import cio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic                  idx_we,
    input  logic [7:0]            wdata,
    input  logic                  host_we,
    input  logic [1:0]            host_sel,
    input  logic [7:0]            host_data,
    output logic [NUM_TMR-1:0]    tmr_en,
    output logic [NUM_TMR-1:0]    tmr_start,
    output logic                  rom_en,
    output logic [7:0]            idx,
    output logic [NUM_PORT*8-1:0] ports
);
    logic [7:0] port_q [NUM_PORT];
    logic [NUM_PORT-1:0] port_clr;

    // Port clear requests: bit 4 -> bytes 0/1, bit 5 -> bytes 2/3
    always_comb begin
        port_clr = '0;
        if (ctrl_we) port_clr = {{2{wdata[5]}}, {2{wdata[4]}}};
    end

    // Start pulses for timers going from disabled to enabled
    always_comb begin
        tmr_start = ctrl_we ? (wdata[NUM_TMR-1:0] & ~tmr_en) : '0;
    end

    // Control byte and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en <= '0;
            rom_en <= 1'b1;
            idx    <= '0;
        end else begin
            if (ctrl_we) begin
                tmr_en <= wdata[NUM_TMR-1:0];
                rom_en <= wdata[7];
            end
            if (idx_we) idx <= wdata;
        end
    end

    // Port byte registers, clear has priority over host load
    for (genvar g = 0; g < NUM_PORT; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n)                              port_q[g] <= '0;
            else if (port_clr[g])                    port_q[g] <= '0;
            else if (host_we && host_sel == 2'(g))   port_q[g] <= host_data;
        end
        assign ports[g*8 +: 8] = port_q[g];
    end

    // R3
    port_clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[4]) |=> (ports[15:0] == 16'h0000));
    // R3
    port_clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[5]) |=> (ports[31:16] == 16'h0000));
    // R4
    overlay_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (rom_en == $past(wdata[7])));
    // R2
    start_then_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_start != '0) |=> ((tmr_en & $past(tmr_start)) == $past(tmr_start)));
    // R6
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> (idx == $past(wdata)));
endmodule

// File: rtl/cio_bootrom.sv
// Module: cio_bootrom
// Built-in boot ROM and the overlay read mux over the RAM underneath.
// Assumes RAM read data is valid in the same cycle as the address.
module cio_bootrom
    import cio_pkg::*;
#(
    parameter int          ROM_BYTES = 64,
    parameter logic [15:0] BOOT_VEC  = 16'hFFC0,
    localparam int         ROM_AW    = $clog2(ROM_BYTES)
) (
    input  logic [ROM_AW-1:0] offset,
    input  logic              rom_en,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        rdata
);
    logic [7:0] rom_tbl [ROM_BYTES];

    // ROM contents computed from the boot vector
    for (genvar g = 0; g < ROM_BYTES; g++) begin : g_rom
        assign rom_tbl[g] = rom_byte(g, ROM_BYTES, BOOT_VEC);
    end

    // Overlay select: ROM while enabled, RAM otherwise
    always_comb begin
        rdata = rom_en ? rom_tbl[offset] : ram_rdata;
    end
endmodule

// File: rtl/copro_io_map.sv
// Module: copro_io_map (top)
// Decodes CPU byte accesses into RAM passthrough, the I/O page registers,
// DSP window strobes, timer strobes and the boot-ROM overlay.
// Assumes one access per cycle; read data is combinational in that cycle.
module copro_io_map
    import cio_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          ROM_BYTES = 64,
    parameter int          CNT_W     = 4,
    parameter logic [15:0] BOOT_VEC  = 16'hFFC0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    output logic                     ram_we,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [7:0]               ram_wdata,
    input  logic [7:0]               ram_rdata,
    input  logic                     host_we,
    input  logic [1:0]               host_sel,
    input  logic [7:0]               host_data,
    output logic                     dsp_rd,
    output logic                     dsp_wr,
    output logic [DSP_AW-1:0]        dsp_addr,
    output logic [7:0]               dsp_wdata,
    input  logic [7:0]               dsp_rdata,
    output logic [NUM_TMR-1:0]       tmr_en,
    output logic [NUM_TMR-1:0]       tmr_start,
    output logic [NUM_TMR-1:0]       tmr_period_we,
    output logic [7:0]               tmr_period_data,
    output logic [NUM_TMR-1:0]       tmr_cnt_clr,
    input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt
);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    region_e               region;
    logic [1:0]            sub;
    logic                  wr, rd;
    logic                  ctrl_we, idx_we;
    logic                  rom_en;
    logic [7:0]            idx;
    logic [NUM_PORT*8-1:0] ports;
    logic [7:0]            rom_rdata;
    logic [CNT_W-1:0]      cnt_sel;

    cio_decode #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_dec (
        .addr   (cpu_addr),
        .region (region),
        .sub    (sub)
    );

    cio_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .idx_we    (idx_we),
        .wdata     (cpu_wdata),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_data (host_data),
        .tmr_en    (tmr_en),
        .tmr_start (tmr_start),
        .rom_en    (rom_en),
        .idx       (idx),
        .ports     (ports)
    );

    cio_bootrom #(.ROM_BYTES(ROM_BYTES), .BOOT_VEC(BOOT_VEC)) u_rom (
        .offset    (cpu_addr[ROM_AW-1:0]),
        .rom_en    (rom_en),
        .ram_rdata (ram_rdata),
        .rdata     (rom_rdata)
    );

    // Qualified access kinds
    always_comb begin
        wr = cpu_req && cpu_we;
        rd = cpu_req && !cpu_we;
    end

    // Write-side strobes per region
    always_comb begin
        ctrl_we       = wr && (region == RG_CTRL);
        idx_we        = wr && (region == RG_IDX);
        ram_we        = wr && (region == RG_RAM || region == RG_ROM);
        dsp_wr        = wr && (region == RG_WIN) && !idx[7];
        dsp_rd        = rd && (region == RG_WIN);
        tmr_period_we = '0;
        tmr_cnt_clr   = '0;
        if (wr && region == RG_PERIOD) tmr_period_we[sub] = 1'b1;
        if (cpu_req && region == RG_COUNT) tmr_cnt_clr[sub] = 1'b1;
    end

    // Passthrough buses
    always_comb begin
        ram_addr        = cpu_addr;
        ram_wdata       = cpu_wdata;
        dsp_addr        = idx[DSP_AW-1:0];
        dsp_wdata       = cpu_wdata;
        tmr_period_data = cpu_wdata;
        cnt_sel         = tmr_cnt[sub*CNT_W +: CNT_W];
    end

    // Read data mux
    always_comb begin
        unique case (region)
            RG_RAM:   cpu_rdata = ram_rdata;
            RG_ROM:   cpu_rdata = rom_rdata;
            RG_IDX:   cpu_rdata = idx;
            RG_WIN:   cpu_rdata = dsp_rdata;
            RG_PORT:  cpu_rdata = ports[sub*8 +: 8];
            RG_COUNT: cpu_rdata = 8'(cnt_sel);
            default:  cpu_rdata = 8'h00;
        endcase
    end

    // R5
    rom_write_reaches_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && (&cpu_addr[ADDR_W-1:ROM_AW])) |-> ram_we);
    // R6
    dsp_strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsp_rd, dsp_wr}));
    // R9
    counter_clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_cnt_clr));
    // R10
    test_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_addr == ADDR_W'(16'h00F0))
            |-> (!ram_we && !dsp_wr && tmr_period_we == '0 && tmr_cnt_clr == '0));
    // R2
    enable_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_we && cpu_addr == ADDR_W'(16'h00F1)) |=> $stable(tmr_en));
endmodule

// File: tb/copro_io_map_test.sv
module copro_io_map_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_data = '0;
    logic        dsp_rd, dsp_wr;
    logic [6:0]  dsp_addr;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic [2:0]  tmr_en, tmr_start, tmr_period_we, tmr_cnt_clr;
    logic [7:0]  tmr_period_data;
    logic [11:0] tmr_cnt = 12'hA53;

    int tests = 0, fails = 0;
    logic [7:0] c_rdata, c_dsp_wdata, c_pdata;
    logic [6:0] c_dsp_addr;
    logic       c_ram_we, c_dsp_rd, c_dsp_wr;
    logic [2:0] c_start, c_pwe, c_clr;

    always #10 clk = ~clk;

    assign ram_rdata = ram_addr[7:0] ^ 8'hA5;
    assign dsp_rdata = {1'b0, dsp_addr} ^ 8'h3C;

    copro_io_map uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .host_we(host_we), .host_sel(host_sel),
        .host_data(host_data), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr),
        .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .tmr_en(tmr_en), .tmr_start(tmr_start), .tmr_period_we(tmr_period_we),
        .tmr_period_data(tmr_period_data), .tmr_cnt_clr(tmr_cnt_clr),
        .tmr_cnt(tmr_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access, optionally with a host load in the same cycle
    task automatic acc(input logic we, input logic [15:0] a, input logic [7:0] d,
                       input logic hwe, input logic [1:0] hs, input logic [7:0] hd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        host_we = hwe; host_sel = hs; host_data = hd;
        #2;
        c_rdata = cpu_rdata; c_ram_we = ram_we; c_dsp_rd = dsp_rd; c_dsp_wr = dsp_wr;
        c_dsp_addr = dsp_addr; c_dsp_wdata = dsp_wdata; c_start = tmr_start;
        c_pwe = tmr_period_we; c_pdata = tmr_period_data; c_clr = tmr_cnt_clr;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        acc(1'b1, a, d, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic rd(input logic [15:0] a);
        acc(1'b0, a, 8'h00, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic t_reset;
        chk("R1 tmr_en", tmr_en, 0);
        rd(16'h00F2); chk("R1 index", c_rdata, 0);
        rd(16'h00F4); chk("R1 port0", c_rdata, 0);
        rd(16'h00F7); chk("R1 port3", c_rdata, 0);
        rd(16'hFFC0); chk("R1 overlay on / R12 rom0", c_rdata, 0);
        rd(16'hFFFE); chk("R12 vec lo", c_rdata, 8'hC0);
        rd(16'hFFFF); chk("R12 vec hi", c_rdata, 8'hFF);
    endtask

    task automatic t_ctrl;
        wr(16'h00F1, 8'h85); chk("R2 start", c_start, 3'b101); chk("R2 en", tmr_en, 3'b101);
        wr(16'h00F1, 8'h87); chk("R2 start partial", c_start, 3'b010); chk("R2 en", tmr_en, 3'b111);
        wr(16'h00F1, 8'h82); chk("R2 start none", c_start, 0); chk("R2 en", tmr_en, 3'b010);
    endtask

    task automatic t_ports;
        for (int i = 0; i < 4; i++) acc(1'b0, 16'h0010, 8'h00, 1'b1, 2'(i), 8'(8'h11 * (i + 1)));
        rd(16'h00F5); chk("R3 port1 loaded", c_rdata, 8'h22);
        wr(16'h00F5, 8'h77); chk("R10 port write no ram", c_ram_we, 0);
        rd(16'h00F5); chk("R10 port unchanged", c_rdata, 8'h22);
        wr(16'h00F1, 8'h92);
        rd(16'h00F4); chk("R3 clr port0", c_rdata, 0);
        rd(16'h00F5); chk("R3 clr port1", c_rdata, 0);
        rd(16'h00F6); chk("R3 keep port2", c_rdata, 8'h33);
        wr(16'h00F1, 8'hA2);
        rd(16'h00F7); chk("R3 clr port3", c_rdata, 0);
        acc(1'b1, 16'h00F1, 8'h92, 1'b1, 2'd0, 8'h5E);
        rd(16'h00F4); chk("R3 clear beats load", c_rdata, 0);
    endtask

    task automatic t_overlay;
        wr(16'hFFC1, 8'h09); chk("R5 ram_we overlay on", c_ram_we, 1);
        rd(16'hFFC1); chk("R4 rom read", c_rdata, 0);
        wr(16'h00F1, 8'h02);
        rd(16'hFFC1); chk("R4 ram read overlay off", c_rdata, 8'hC1 ^ 8'hA5);
        wr(16'hFFFF, 8'h01); chk("R5 ram_we overlay off", c_ram_we, 1);
    endtask

    task automatic t_dsp;
        wr(16'h00F2, 8'h15);
        rd(16'h00F2); chk("R6 index read", c_rdata, 8'h15);
        rd(16'h00F3); chk("R6 rd strobe", c_dsp_rd, 1); chk("R6 addr", c_dsp_addr, 7'h15);
        chk("R6 data", c_rdata, 8'h15 ^ 8'h3C);
        wr(16'h00F3, 8'hAB); chk("R7 wr strobe", c_dsp_wr, 1); chk("R7 wdata", c_dsp_wdata, 8'hAB);
        wr(16'h00F2, 8'h95);
        rd(16'h00F3); chk("R6 masked addr", c_dsp_addr, 7'h15);
        wr(16'h00F3, 8'hCD); chk("R7 dropped", c_dsp_wr, 0);
    endtask

    task automatic t_timers;
        wr(16'h00FB, 8'h40); chk("R8 period we", c_pwe, 3'b010); chk("R8 period data", c_pdata, 8'h40);
        wr(16'h00FC, 8'h00); chk("R8 period we2", c_pwe, 3'b100);
        rd(16'h00FB); chk("R8 period read 0", c_rdata, 0);
        rd(16'h00F0); chk("R8 test read 0", c_rdata, 0);
        rd(16'h00F1); chk("R8 ctrl read 0", c_rdata, 0);
        rd(16'h00FE); chk("R9 cnt1", c_rdata, 5); chk("R9 clr on read", c_clr, 3'b010);
        rd(16'h00FF); chk("R9 cnt2", c_rdata, 8'h0A);
        wr(16'h00FD, 8'hFF); chk("R9 clr on write", c_clr, 3'b001); chk("R9 no ram", c_ram_we, 0);
    endtask

    task automatic t_test_reg;
        wr(16'h00F0, 8'hFF);
        chk("R10 no ram_we", c_ram_we, 0); chk("R10 no dsp", c_dsp_wr, 0);
        chk("R10 no period", c_pwe, 0); chk("R10 no clr", c_clr, 0);
        chk("R10 en kept", tmr_en, 3'b010);
    endtask

    task automatic t_ram;
        wr(16'h0010, 8'h01); chk("R11 low ram", c_ram_we, 1);
        wr(16'h00F8, 8'h02); chk("R11 F8 ram", c_ram_we, 1);
        wr(16'hFFBF, 8'h03); chk("R11 below rom", c_ram_we, 1);
        rd(16'h00F9); chk("R11 F9 read", c_rdata, 8'hF9 ^ 8'hA5);
        rd(16'h1234); chk("R11 mid read", c_rdata, 8'h34 ^ 8'hA5);
    endtask

    initial begin : watchdog
        #2000000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_ctrl;
        t_ports;
        t_overlay;
        t_dsp;
        t_timers;
        t_test_reg;
        t_ram;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule